// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is one DMA channel that carries data between a single peripheral FIFO port and a word-wide memory port. Software latches the transfer setup with a start pulse: the direction, a beat width of one byte or one 32-bit word, a base byte address, a byte count and an almost-done level. In receive mode the channel takes beats from the peripheral into a small internal buffer and writes them to memory. In transmit mode it reads memory words into the buffer and presents them to the peripheral.

A remaining-byte counter starts at the programmed size and goes down as the channel accepts beats from the source side. While the transfer runs, software can add bytes to it. The extra data uses the addresses that follow the current end. Software can also hold off peripheral fetching on a receive channel, or abort the transfer. Status outputs show running, done, almost-done, buffer-empty and the live remaining count.

Top module: `pdma_channel`

## Requirements
- R1: After reset, running_o, done_o, almost_o, mem_req_o, per_rx_ready_o and per_tx_valid_o are 0, remain_o is 0 and fifo_empty_o is 1.
- R2: A start_i pulse while idle latches dir_tx_i, wide_i, base_addr_i, size_i and thresh_i. On the next cycle running_o is 1 and remain_o equals size_i. A start_i while running has no effect.
- R3: With wide_i=1 each beat is a 32-bit word, the count drops by 4 and the memory address steps by 4. With wide_i=0 each beat is one byte carried in bits [7:0] with the upper bits forced to 0, the count drops by 1 and the address steps by 1.
- R4: dir_tx_i=0 selects receive: peripheral beats are written to memory (mem_we_o=1) in arrival order at base, base+beat and so on. dir_tx_i=1 selects transmit: memory words read from the same address sequence are passed to the peripheral in order.
- R5: The count decreases when the source side accepts a beat. A final beat taken while fewer bytes than one beat remain sets the count to 0, so ceil(size/beat) beats move.
- R6: When the count is 0 and the buffer is empty, done_o rises and running_o falls on the same clock edge. done_o stays high until the next accepted start or a stop during a transfer.
- R7: ext_i with ext_len_i while running adds ext_len_i to the count, and the data continues at the next addresses. ext_i while idle leaves the count at 0 and the status unchanged.
- R8: An extend in the same cycle as a beat decrement gives count − beat + ext_len_i. Neither update is lost.
- R9: On a receive channel with flush_i=1, per_rx_ready_o is 0, the count holds and running_o stays 1. Dropping flush_i resumes fetching.
- R10: flush_i has no effect on a transmit channel. The transfer completes with all beats delivered.
- R11: stop_i during a transfer makes running_o=0, done_o=0, remain_o=0 and fifo_empty_o=1 on the next cycle. stop_i while idle leaves running_o and done_o as they were and remain_o at 0.
- R12: almost_o is 1 exactly while running_o is 1 and remain_o ≤ the latched threshold.
- R13: fifo_empty_o is 1 only when the internal buffer holds no beat. A full buffer (FIFO_DEPTH beats) blocks further source fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, latches the setup |
| dir_tx_i | input | 1 | 0 receive, 1 transmit |
| wide_i | input | 1 | 1 word beats, 0 byte beats |
| base_addr_i | input | ADDR_W | Start byte address |
| size_i | input | CNT_W | Byte count |
| thresh_i | input | CNT_W | Almost-done level |
| ext_i | input | 1 | Extend pulse |
| ext_len_i | input | CNT_W | Bytes added by an extend |
| stop_i | input | 1 | Abort pulse |
| flush_i | input | 1 | Hold off peripheral fetching (receive only) |
| per_rx_valid_i | input | 1 | Peripheral has a beat |
| per_rx_data_i | input | 32 | Peripheral beat data |
| per_rx_ready_o | output | 1 | Channel takes the peripheral beat |
| per_tx_valid_o | output | 1 | Channel offers a beat to the peripheral |
| per_tx_data_o | output | 32 | Beat data to the peripheral |
| per_tx_ready_i | input | 1 | Peripheral takes the beat |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory completes the access this cycle |
| running_o | output | 1 | Transfer active |
| done_o | output | 1 | Transfer completed |
| almost_o | output | 1 | Count at or below threshold |
| fifo_empty_o | output | 1 | Internal buffer empty |
| remain_o | output | CNT_W | Remaining byte count |

## Verification
Assertions check on every cycle that done and running are never high together, and that running only falls with done or after a stop. They also check that a stop clears the count, that the count never grows without a start or an extend, and that a flushed or transmit-mode channel never asserts peripheral ready. The bench scenarios are needed for the data order and address sequence in each direction and width, and for the remainder beat. They also cover the sum of an extend with a same-cycle decrement, the buffer filling against a stalled memory, and the idle no-effect cases of extend and stop.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } pdma_dir_e;

  // Byte beats keep only the low lane; the rest reads as zero.
  function automatic logic [WORD_W-1:0] beat_mask(input logic wide,
                                                  input logic [WORD_W-1:0] d);
    return wide ? d : {{(WORD_W-8){1'b0}}, d[7:0]};
  endfunction
endpackage

// File: rtl/pdma_fifo.sv
module pdma_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] fill_q;
  logic          do_push, do_pop;

  assign empty   = (fill_q == '0);
  assign full    = (fill_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rp_q];

  // Storage has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/pdma_remaining.sv
module pdma_remaining #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             take,
  input  logic             wide,
  input  logic             ext_en,
  input  logic [CNT_W-1:0] ext_len,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, step, dec, add;

  assign step  = wide ? CNT_W'(4) : CNT_W'(1);
  assign dec   = take ? ((cnt_q < step) ? cnt_q : step) : '0;
  assign add   = ext_en ? ext_len : '0;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else               cnt_q <= cnt_q - dec + add;
  end
endmodule

// File: rtl/pdma_addr_ptr.sv
module pdma_addr_ptr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  assign addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (adv)  addr_q <= addr_q + (wide ? ADDR_W'(4) : ADDR_W'(1));
  end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dir_tx_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              ext_i,
  input  logic [CNT_W-1:0]  ext_len_i,
  input  logic              stop_i,
  input  logic              flush_i,
  input  logic              per_rx_valid_i,
  input  logic [31:0]       per_rx_data_i,
  output logic              per_rx_ready_o,
  output logic              per_tx_valid_o,
  output logic [31:0]       per_tx_data_o,
  input  logic              per_tx_ready_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              running_o,
  output logic              done_o,
  output logic              almost_o,
  output logic              fifo_empty_o,
  output logic [CNT_W-1:0]  remain_o
);
  import pdma_pkg::*;

  logic             run_q, done_q, wide_q;
  pdma_dir_e        dir_q;
  logic [CNT_W-1:0] thr_q;
  logic             tx_mode;

  logic             start_ok, abort, finish, ext_en;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  logic             buf_empty, buf_full, buf_push, buf_pop;
  logic [WORD_W-1:0] buf_din, buf_dout;

  logic             rx_src_rdy, rx_take, tx_fetch, tx_take;
  logic             rx_sink, mem_hs;
  logic [ADDR_W-1:0] addr;

  assign tx_mode  = (dir_q == DIR_TX);
  assign cnt_zero = (cnt == '0);
  assign start_ok = start_i && !run_q && !stop_i;
  assign abort    = stop_i && run_q;
  assign ext_en   = ext_i && run_q && !stop_i;

  // Source side: peripheral (receive) or memory reads (transmit).
  assign rx_src_rdy = run_q && !tx_mode && !flush_i && !buf_full && !cnt_zero;
  assign rx_take    = rx_src_rdy && per_rx_valid_i;
  assign tx_fetch   = run_q && tx_mode && !buf_full && !cnt_zero;
  assign tx_take    = tx_fetch && mem_ready_i;

  // Sink side: memory writes (receive) or peripheral (transmit).
  assign rx_sink    = run_q && !tx_mode && !buf_empty;

  assign buf_push = rx_take || tx_take;
  assign buf_din  = beat_mask(wide_q, tx_mode ? mem_rdata_i : per_rx_data_i);
  assign buf_pop  = (rx_sink && mem_ready_i) || (per_tx_valid_o && per_tx_ready_i);

  assign mem_req_o   = tx_fetch || rx_sink;
  assign mem_we_o    = rx_sink;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = buf_dout;
  assign mem_hs      = mem_req_o && mem_ready_i;

  assign per_rx_ready_o = rx_src_rdy;
  assign per_tx_valid_o = run_q && tx_mode && !buf_empty;
  assign per_tx_data_o  = buf_dout;

  // Completion waits for both an empty count and a drained buffer;
  // a same-cycle non-zero extend keeps the transfer alive.
  assign finish = run_q && cnt_zero && buf_empty && !(ext_en && (ext_len_i != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_RX;
      wide_q <= 1'b0;
      thr_q  <= '0;
    end else if (abort) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_ok) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      dir_q  <= pdma_dir_e'(dir_tx_i);
      wide_q <= wide_i;
      thr_q  <= thresh_i;
    end else if (finish) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end
  end

  pdma_remaining #(.CNT_W(CNT_W)) u_remain (
    .clk      (clk),
    .rst      (rst),
    .clear    (stop_i),
    .load     (start_ok),
    .load_val (size_i),
    .take     (buf_push),
    .wide     (wide_q),
    .ext_en   (ext_en),
    .ext_len  (ext_len_i),
    .cnt_o    (cnt)
  );

  pdma_addr_ptr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (start_ok),
    .load_val (base_addr_i),
    .adv      (mem_hs),
    .wide     (wide_q),
    .addr_o   (addr)
  );

  pdma_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .clr   (stop_i || start_ok),
    .push  (buf_push),
    .din   (buf_din),
    .pop   (buf_pop),
    .dout  (buf_dout),
    .empty (buf_empty),
    .full  (buf_full)
  );

  assign running_o    = run_q;
  assign done_o       = done_q;
  assign almost_o     = run_q && (cnt <= thr_q);
  assign fifo_empty_o = buf_empty;
  assign remain_o     = cnt;
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             ext_i,
  input logic             stop_i,
  input logic             flush_i,
  input logic             tx_mode,
  input logic             per_rx_ready_o,
  input logic             per_tx_valid_o,
  input logic             mem_req_o,
  input logic             running_o,
  input logic             done_o,
  input logic             fifo_empty_o,
  input logic [CNT_W-1:0] remain_o
);
  // R6
  done_run_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && running_o));

  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running_o) |-> (done_o || $past(stop_i)));

  // R6
  done_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (remain_o == '0) && fifo_empty_o);

  // R11
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (remain_o == '0) && !running_o && fifo_empty_o);

  // R9
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_i && !tx_mode) |-> !per_rx_ready_o);

  // R10
  tx_no_rx_chk: assert property (@(posedge clk) disable iff (rst)
    tx_mode |-> !per_rx_ready_o);

  // R5
  no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_i && !start_i) |=> (remain_o <= $past(remain_o)));

  // R13
  rx_empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty_o && !tx_mode) |-> !mem_req_o);

  // R4
  tx_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    per_tx_valid_o |-> (tx_mode && !fifo_empty_o));
endmodule

bind pdma_channel pdma_channel_chk #(.CNT_W(CNT_W)) u_pdma_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .ext_i          (ext_i),
  .stop_i         (stop_i),
  .flush_i        (flush_i),
  .tx_mode        (tx_mode),
  .per_rx_ready_o (per_rx_ready_o),
  .per_tx_valid_o (per_tx_valid_o),
  .mem_req_o      (mem_req_o),
  .running_o      (running_o),
  .done_o         (done_o),
  .fifo_empty_o   (fifo_empty_o),
  .remain_o       (remain_o)
);

// File: tb/test_pdma_channel.sv
`timescale 1ns/1ps
module test_pdma_channel;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 16;

  // {dir_tx, wide, slow, size[7:0], thr[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 8'd16, 8'd4},
    {1'b0, 1'b0, 1'b1, 8'd7,  8'd3},
    {1'b1, 1'b1, 1'b1, 8'd12, 8'd0},
    {1'b1, 1'b0, 1'b0, 8'd5,  8'd5},
    {1'b0, 1'b1, 1'b0, 8'd6,  8'd0},
    {1'b1, 1'b1, 1'b0, 8'd0,  8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, dir_tx_i = 0, wide_i = 0, ext_i = 0, stop_i = 0, flush_i = 0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic [CNT_W-1:0]  size_i = '0, thresh_i = '0, ext_len_i = '0;
  logic per_rx_valid_i, per_rx_ready_o, per_tx_valid_o, per_tx_ready_i;
  logic [31:0] per_rx_data_i, per_tx_data_o, mem_wdata_o, mem_rdata_i;
  logic mem_req_o, mem_we_o, mem_ready_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic running_o, done_o, almost_o, fifo_empty_o;
  logic [CNT_W-1:0] remain_o;

  logic rx_valid = 1'b1, slow = 1'b0, hold_mem = 1'b0, tick = 1'b0, cnt_clr = 1'b0;
  int   tests = 0, fails = 0;
  int   rx_beats = 0, wr_idx = 0, rd_idx = 0, tx_out = 0;
  logic [ADDR_W-1:0] exp_base = '0;
  logic exp_wide = 1'b0;
  logic [CNT_W-1:0] exp_thr = '0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input int k);
    logic [7:0] b;
    b = k[7:0];
    return {8'hC3, b ^ 8'h5A, ~b, b + 8'h11};
  endfunction

  function automatic logic [31:0] memfun(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'h96, 8'h3C, a[7:0] + 8'h07, a[7:0]};
  endfunction

  function automatic logic [31:0] msk(input logic w, input logic [31:0] d);
    return w ? d : {24'h0, d[7:0]};
  endfunction

  assign per_rx_valid_i = rx_valid;
  assign per_rx_data_i  = pat(rx_beats);
  assign mem_ready_i    = hold_mem ? 1'b0 : (slow ? tick : 1'b1);
  assign per_tx_ready_i = slow ? ~tick : 1'b1;
  assign mem_rdata_i    = memfun(mem_addr_o);

  pdma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(4)) i_pdma_channel (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_tx_i(dir_tx_i), .wide_i(wide_i),
    .base_addr_i(base_addr_i), .size_i(size_i), .thresh_i(thresh_i),
    .ext_i(ext_i), .ext_len_i(ext_len_i), .stop_i(stop_i), .flush_i(flush_i),
    .per_rx_valid_i(per_rx_valid_i), .per_rx_data_i(per_rx_data_i),
    .per_rx_ready_o(per_rx_ready_o), .per_tx_valid_o(per_tx_valid_o),
    .per_tx_data_o(per_tx_data_o), .per_tx_ready_i(per_tx_ready_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .running_o(running_o), .done_o(done_o), .almost_o(almost_o),
    .fifo_empty_o(fifo_empty_o), .remain_o(remain_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial forever begin
    @(posedge clk); #1; tick = ~tick;
  end

  // Handshake counters advance on the edge where the handshake completes.
  always @(posedge clk) begin
    if (cnt_clr) begin
      rx_beats <= 0; wr_idx <= 0; rd_idx <= 0; tx_out <= 0;
    end else begin
      if (per_rx_valid_i && per_rx_ready_o) rx_beats <= rx_beats + 1;
      if (mem_req_o && mem_ready_i && mem_we_o) wr_idx <= wr_idx + 1;
      if (mem_req_o && mem_ready_i && !mem_we_o) rd_idx <= rd_idx + 1;
      if (per_tx_valid_o && per_tx_ready_i) tx_out <= tx_out + 1;
    end
  end

  // Mid-cycle monitor of data order, addresses and the almost flag.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req_o && mem_ready_i) begin
        if (mem_we_o) begin
          chk("R3 write address", mem_addr_o, exp_base + wr_idx * (exp_wide ? 4 : 1));
          chk("R4 write data", mem_wdata_o, msk(exp_wide, pat(wr_idx)));
        end else begin
          chk("R3 read address", mem_addr_o, exp_base + rd_idx * (exp_wide ? 4 : 1));
        end
      end
      if (per_tx_valid_o && per_tx_ready_i)
        chk("R4 tx data", per_tx_data_o,
            msk(exp_wide, memfun(exp_base + tx_out * (exp_wide ? 4 : 1))));
      if (running_o)
        chk("R12 almost", 32'(almost_o), 32'(remain_o <= exp_thr));
    end
  end

  task automatic start_xfer(input logic tx, input logic w, input logic [ADDR_W-1:0] base,
                            input logic [CNT_W-1:0] sz, input logic [CNT_W-1:0] thr);
    @(posedge clk); #1;
    dir_tx_i = tx; wide_i = w; base_addr_i = base; size_i = sz; thresh_i = thr;
    exp_base = base; exp_wide = w; exp_thr = thr;
    start_i = 1'b1; cnt_clr = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0; cnt_clr = 1'b0;
    @(negedge clk);
    chk("R2 running after start", 32'(running_o), 32'd1);
    chk("R2 count loaded", 32'(remain_o), 32'(sz));
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  task automatic pulse_stop();
    @(posedge clk); #1; stop_i = 1'b1;
    @(posedge clk); #1; stop_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_tb();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 running", 32'(running_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 almost", 32'(almost_o), 0);
    chk("R1 remain", 32'(remain_o), 0);
    chk("R1 fifo empty", 32'(fifo_empty_o), 1);
    chk("R1 idle ports", {29'd0, mem_req_o, per_rx_ready_o, per_tx_valid_o}, 0);

    // Table of transfers
    for (int v = 0; v < 6; v++) begin
      logic [18:0] e;
      int beats;
      e = VEC[v];
      slow = e[16];
      beats = e[17] ? (int'(e[15:8]) + 3) / 4 : int'(e[15:8]);
      start_xfer(e[18], e[17], 32'h200 + 32'(v * 64), CNT_W'(e[15:8]), CNT_W'(e[7:0]));
      wait_done(2000);
      chk("R6 done", 32'(done_o), 1);
      chk("R6 running cleared", 32'(running_o), 0);
      chk("R5 count zero", 32'(remain_o), 0);
      chk("R13 buffer drained", 32'(fifo_empty_o), 1);
      if (e[18]) begin
        chk("R4 tx reads", rd_idx, beats);
        chk("R5 tx beats", tx_out, beats);
      end else begin
        chk("R4 rx takes", rx_beats, beats);
        chk("R5 rx writes", wr_idx, beats);
      end
    end
    slow = 1'b0;

    // R7 extend while idle is ignored
    @(posedge clk); #1; ext_i = 1'b1; ext_len_i = 16'd8;
    @(posedge clk); #1; ext_i = 1'b0;
    @(negedge clk);
    chk("R7 idle extend count", 32'(remain_o), 0);
    chk("R7 idle extend running", 32'(running_o), 0);
    chk("R7 idle extend done", 32'(done_o), 1);

    // R11 stop while idle
    pulse_stop();
    chk("R11 idle stop done kept", 32'(done_o), 1);
    chk("R11 idle stop running", 32'(running_o), 0);
    chk("R11 idle stop count", 32'(remain_o), 0);

    // R2 start ignored while running
    rx_valid = 1'b0;
    start_xfer(1'b0, 1'b1, 32'h1000, 16'd8, 16'd0);
    @(posedge clk); #1; start_i = 1'b1; size_i = 16'd100;
    @(posedge clk); #1; start_i = 1'b0;
    @(negedge clk);
    chk("R2 restart ignored", 32'(remain_o), 8);
    pulse_stop();

    // R7 extend during a transfer
    start_xfer(1'b0, 1'b1, 32'h100, 16'd8, 16'd0);
    repeat (3) @(negedge clk);
    chk("R7 stalled count", 32'(remain_o), 8);
    @(posedge clk); #1; ext_i = 1'b1; ext_len_i = 16'd8;
    @(posedge clk); #1; ext_i = 1'b0;
    @(negedge clk);
    chk("R7 extended count", 32'(remain_o), 16);
    rx_valid = 1'b1;
    wait_done(500);
    chk("R7 extended beats", wr_idx, 4);
    chk("R7 done after extend", 32'(done_o), 1);

    // R8 extend in the same cycle as a decrement
    start_xfer(1'b0, 1'b0, 32'h40, 16'd10, 16'd0);
    begin
      logic [CNT_W-1:0] c0;
      logic rdy;
      @(posedge clk); #1;
      c0 = remain_o; rdy = per_rx_ready_o;
      ext_i = 1'b1; ext_len_i = 16'd5;
      @(posedge clk); #1; ext_i = 1'b0;
      chk("R8 beat taken", 32'(rdy), 1);
      chk("R8 combined update", 32'(remain_o), 32'(c0) - 1 + 5);
    end
    wait_done(500);
    chk("R8 total beats", wr_idx, 15);

    // R9 flush on receive
    flush_i = 1'b1;
    start_xfer(1'b0, 1'b1, 32'h300, 16'd16, 16'd0);
    repeat (10) @(negedge clk);
    chk("R9 ready held low", 32'(per_rx_ready_o), 0);
    chk("R9 count held", 32'(remain_o), 16);
    chk("R9 still running", 32'(running_o), 1);
    chk("R9 nothing taken", rx_beats, 0);
    chk("R13 empty while flushed", 32'(fifo_empty_o), 1);
    flush_i = 1'b0;
    wait_done(500);
    chk("R9 resumed beats", rx_beats, 4);

    // R10 flush ignored on transmit
    flush_i = 1'b1;
    start_xfer(1'b1, 1'b1, 32'h380, 16'd16, 16'd0);
    wait_done(500);
    chk("R10 done with flush", 32'(done_o), 1);
    chk("R10 beats with flush", tx_out, 4);
    flush_i = 1'b0;

    // R12 almost flag at start
    rx_valid = 1'b0;
    start_xfer(1'b0, 1'b1, 32'h500, 16'd16, 16'd8);
    chk("R12 above threshold", 32'(almost_o), 0);
    pulse_stop();
    start_xfer(1'b0, 1'b1, 32'h500, 16'd16, 16'd16);
    chk("R12 at threshold", 32'(almost_o), 1);
    rx_valid = 1'b1;
    wait_done(500);
    chk("R12 low when finished", 32'(almost_o), 0);

    // R13 buffer fills against a stalled memory
    hold_mem = 1'b1;
    start_xfer(1'b0, 1'b1, 32'h600, 16'd32, 16'd0);
    repeat (8) @(negedge clk);
    chk("R13 buffer not empty", 32'(fifo_empty_o), 0);
    chk("R13 full blocks fetch", 32'(per_rx_ready_o), 0);
    chk("R13 beats buffered", rx_beats, 4);
    chk("R5 count after four beats", 32'(remain_o), 16);
    hold_mem = 1'b0;
    wait_done(500);
    chk("R13 all beats written", wr_idx, 8);

    // R11 stop during a transfer
    slow = 1'b1;
    start_xfer(1'b0, 1'b0, 32'h700, 16'd40, 16'd0);
    repeat (6) @(posedge clk);
    pulse_stop();
    chk("R11 running cleared", 32'(running_o), 0);
    chk("R11 count cleared", 32'(remain_o), 0);
    chk("R11 done low", 32'(done_o), 0);
    chk("R11 buffer emptied", 32'(fifo_empty_o), 1);
    slow = 1'b0;

    repeat (3) @(negedge clk);
    finish_tb();
  end
endmodule